// File: doc/BRIEF.md
# Overlapping Window PE Resolver

This block takes a 50-bit host-bus address and checks it against sixteen programmable address windows at the same time. Each window has a base, a power-of-two size, an enable and a mode. A window in single mode answers with its own programmed PE number. A window in segmented mode is split into 256 equal segments, and it answers with the index of the segment that was hit. The address itself goes through unchanged.

Windows may overlap. The lowest-numbered enabled window that matches wins. A small window can therefore sit on top of a large backing window, as long as the backing window is placed at the highest index. An address that no enabled window claims raises a miss flag.

Configuration is written through a port that takes a window index, a field select and a data word. The lookup result is registered and appears one clock after the request.

Top module: `pe_window_resolver`

## Requirements
- R1: After a synchronous active-high reset, all windows are disabled and `res_valid` is 0. A lookup made before any configuration returns a miss.
- R2: `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise. The result fields change only when `res_valid` rises.
- R3: `res_addr` equals the looked-up address, with no translation.
- R4: A window covers `[base, base + 2^L)`, where L is its size field. L is clamped to a minimum of 8 and a maximum of 50. The low L bits of the base are ignored.
- R5: A hit on a single-mode window returns that window's programmed PE number on `res_pe`.
- R6: A hit on a segmented window returns address bits `[L-1:L-8]` (the segment index, 0..255) on `res_pe`.
- R7: When several enabled windows match, the lowest index wins, and `res_win` carries that index.
- R8: When no enabled window matches, `res_miss` is 1, `res_hit` is 0, and `res_pe` and `res_win` are 0. `res_hit` and `res_miss` are never both set with `res_valid`.
- R9: Configuration port field codes:
  - 0 = base (all 50 data bits)
  - 1 = size L (data bits [5:0])
  - 2 = PE number (data bits [7:0])
  - 3 = control (data bit 0 = enable, bit 1 = segmented mode)
- R10: A lookup in the same cycle as a configuration write uses the old configuration. The next lookup sees the new one.
- R11: A disabled window never matches, even when its range covers the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 4 | Window index for the write |
| cfg_field | input | 2 | Field select (see R9) |
| cfg_data | input | 50 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 50 | Address to resolve |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some window claimed the address |
| res_miss | output | 1 | No window claimed the address |
| res_win | output | 4 | Index of the winning window |
| res_pe | output | 8 | Resolved PE number |
| res_addr | output | 50 | Address forwarded unchanged |

## Verification
A configuration write and a lookup can arrive in the same cycle. The bench provokes this by disabling the backing window and then, on a single clock edge, re-enabling it while it looks up an address that only that window covers. The result of that lookup must still be a miss. A lookup issued right afterwards must hit with the backing window's PE number. Together these two results show that the lookup reads the configuration held before the edge, and that the new configuration is in effect one cycle later.

// File: rtl/pewin_pkg.sv
package pewin_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_LOG2 = 2'd1,
    FLD_PE   = 2'd2,
    FLD_CTRL = 2'd3
  } cfg_field_e;

  function automatic int clamp_log2(input int lg, input int lo, input int hi);
    if (lg < lo) return lo;
    if (lg > hi) return hi;
    return lg;
  endfunction
endpackage

// File: rtl/pewin_cfg_regs.sv
module pewin_cfg_regs #(
  parameter int NUM_WIN   = 16,
  parameter int ADDR_W    = 50,
  parameter int LG_W      = 6,
  parameter int PE_W      = 8,
  parameter int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [WIN_IDX_W-1:0]             win,
  input  logic [1:0]                       field,
  input  logic [ADDR_W-1:0]                data,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_o,
  output logic [NUM_WIN-1:0][LG_W-1:0]     lg_o,
  output logic [NUM_WIN-1:0][PE_W-1:0]     pe_o,
  output logic [NUM_WIN-1:0]               en_o,
  output logic [NUM_WIN-1:0]               seg_o
);
  import pewin_pkg::*;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = we && (int'(win) == w);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[w] <= '0;
        lg_o[w]   <= '0;
        pe_o[w]   <= '0;
        en_o[w]   <= 1'b0;
        seg_o[w]  <= 1'b0;
      end else if (sel) begin
        case (cfg_field_e'(field))
          FLD_BASE: base_o[w] <= data;
          FLD_LOG2: lg_o[w]   <= data[LG_W-1:0];
          FLD_PE:   pe_o[w]   <= data[PE_W-1:0];
          FLD_CTRL: begin
            en_o[w]  <= data[0];
            seg_o[w] <= data[1];
          end
          default: ;
        endcase
      end
    end
  end

  // R9: a control write lands in the addressed window's enable
  assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && field == 2'd3) |=> (en_o[$past(win)] == $past(data[0])));
endmodule

// File: rtl/pewin_match.sv
module pewin_match #(
  parameter int ADDR_W   = 50,
  parameter int LG_W     = 6,
  parameter int PE_W     = 8,
  parameter int SEG_BITS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LG_W-1:0]   lg,
  input  logic [PE_W-1:0]   pe_cfg,
  input  logic              en,
  input  logic              seg_mode,
  output logic              hit,
  output logic [PE_W-1:0]   pe
);
  import pewin_pkg::*;

  int                lg_eff;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    lg_eff  = clamp_log2(int'(lg), SEG_BITS, ADDR_W);
    mask    = {ADDR_W{1'b1}} << lg_eff;
    offset  = addr & ~mask;
    shifted = offset >> (lg_eff - SEG_BITS);
    hit     = en && (((addr ^ base) & mask) == '0);
    pe      = seg_mode ? PE_W'(shifted[SEG_BITS-1:0]) : pe_cfg;
  end
endmodule

// File: rtl/pewin_prio.sv
module pewin_prio #(
  parameter int NUM_WIN   = 16,
  parameter int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]   req,
  output logic                 any,
  output logic [WIN_IDX_W-1:0] idx,
  output logic [NUM_WIN-1:0]   gnt
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    gnt = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = WIN_IDX_W'(i);
        gnt = '0;
        gnt[i] = 1'b1;
      end
    end
  end

  // R7: at most one window granted, and only a requesting one
  always_comb begin
    assert_grant_onehot_R7: assert ($onehot0(gnt));
    assert_grant_subset_R7: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/pe_window_resolver.sv
module pe_window_resolver #(
  parameter int NUM_WIN   = 16,
  parameter int ADDR_W    = 50,
  parameter int LG_W      = 6,
  parameter int PE_W      = 8,
  parameter int SEG_BITS  = 8,
  parameter int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [WIN_IDX_W-1:0] cfg_win,
  input  logic [1:0]           cfg_field,
  input  logic [ADDR_W-1:0]    cfg_data,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic                 res_miss,
  output logic [WIN_IDX_W-1:0] res_win,
  output logic [PE_W-1:0]      res_pe,
  output logic [ADDR_W-1:0]    res_addr
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  logic [NUM_WIN-1:0][LG_W-1:0]   lg_q;
  logic [NUM_WIN-1:0][PE_W-1:0]   pe_q;
  logic [NUM_WIN-1:0]             en_q;
  logic [NUM_WIN-1:0]             seg_q;
  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0][PE_W-1:0]   win_pe;
  logic [NUM_WIN-1:0]             gnt;
  logic                           any_hit;
  logic [WIN_IDX_W-1:0]           win_idx;
  logic [PE_W-1:0]                sel_pe;

  pewin_cfg_regs #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .LG_W(LG_W), .PE_W(PE_W), .WIN_IDX_W(WIN_IDX_W)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .win(cfg_win), .field(cfg_field), .data(cfg_data),
    .base_o(base_q), .lg_o(lg_q), .pe_o(pe_q), .en_o(en_q), .seg_o(seg_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    pewin_match #(
      .ADDR_W(ADDR_W), .LG_W(LG_W), .PE_W(PE_W), .SEG_BITS(SEG_BITS)
    ) match_i (
      .addr(lk_addr), .base(base_q[w]), .lg(lg_q[w]), .pe_cfg(pe_q[w]),
      .en(en_q[w]), .seg_mode(seg_q[w]), .hit(win_hit[w]), .pe(win_pe[w])
    );
  end

  pewin_prio #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) prio_i (
    .req(win_hit), .any(any_hit), .idx(win_idx), .gnt(gnt)
  );

  always_comb begin
    sel_pe = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (gnt[i]) sel_pe = win_pe[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_win   <= '0;
      res_pe    <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit  <= any_hit;
        res_miss <= !any_hit;
        res_win  <= any_hit ? win_idx : '0;
        res_pe   <= any_hit ? sel_pe : '0;
        res_addr <= lk_addr;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !res_valid);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && $stable(res_pe) && $stable(res_win)));
  assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (res_addr == $past(lk_addr)));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_miss) |-> (res_pe == '0 && res_win == '0));
endmodule

// File: tb/pe_window_resolver_tb_top.sv
module pe_window_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 50;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [3:0]    cfg_win;
  logic [1:0]    cfg_field;
  logic [AW-1:0] cfg_data;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          res_valid, res_hit, res_miss;
  logic [3:0]    res_win;
  logic [7:0]    res_pe;
  logic [AW-1:0] res_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_window_resolver dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
    .cfg_data(cfg_data), .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win), .res_pe(res_pe),
    .res_addr(res_addr)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          hit;
    logic [3:0]    win;
    logic [7:0]    pe;
  } vec_t;

  // Config used by the table: w15 backing single pe 77 (whole space),
  // w3 0x1000_0000/16MB segmented, w1 0x1000_0000/1MB single pe 21,
  // w7 3<<48 / 2^40 segmented, w0 disabled 0x1000_0000/4KB pe 05.
  localparam vec_t VEC [8] = '{
    '{50'h0000_1000_0010,   1'b1, 4'd1,  8'h21}, // R7 w1 over w3/w15, R11 w0 off
    '{50'h0000_1020_0000,   1'b1, 4'd3,  8'h20}, // R6 segment 0x20
    '{50'h0000_10FF_FFFF,   1'b1, 4'd3,  8'hFF}, // R6 last segment
    '{50'h0000_1100_0000,   1'b1, 4'd15, 8'h77}, // R4 just past w3, R5
    '{50'h3_00AB_1234_5678, 1'b1, 4'd7,  8'hAB}, // R6 large window
    '{50'h3_0100_0000_0000, 1'b1, 4'd15, 8'h77}, // R4 past w7
    '{50'h0000_0FFF_FFFF,   1'b1, 4'd15, 8'h77}, // R4 below w1/w3
    '{50'h0000_100F_FFFF,   1'b1, 4'd1,  8'h21}  // R4 last byte of w1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input int f, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 4'(w); cfg_field = 2'(f); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic hit, input logic [3:0] w,
                            input logic [7:0] pe, input logic [AW-1:0] a);
    check(req, {63'd0, res_valid}, 64'd1);
    check(req, {62'd0, res_hit, res_miss}, {62'd0, hit, !hit});
    check(req, {60'd0, res_win}, {60'd0, w});
    check(req, {56'd0, res_pe}, {56'd0, pe});
    check("R3", {14'd0, res_addr}, {14'd0, a});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_win = '0; cfg_field = '0; cfg_data = '0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {63'd0, res_valid}, 64'd0);
    look(50'h0000_1234_5678);
    expect_res("R1", 1'b0, 4'd0, 8'h00, 50'h0000_1234_5678);

    // R9 field encoding used to build the configuration
    wr(15, 0, 50'h0);               wr(15, 1, 50'd50);
    wr(15, 2, 50'h77);              wr(15, 3, 50'h1);
    wr(3, 0, 50'h1000_0000);        wr(3, 1, 50'd24);  wr(3, 3, 50'h3);
    wr(1, 0, 50'h1000_0000);        wr(1, 1, 50'd20);
    wr(1, 2, 50'h21);               wr(1, 3, 50'h1);
    wr(7, 0, 50'h3_0000_0000_0000); wr(7, 1, 50'd40);  wr(7, 3, 50'h3);
    wr(0, 0, 50'h1000_0000);        wr(0, 1, 50'd12);
    wr(0, 2, 50'h05);               wr(0, 3, 50'h0);

    foreach (VEC[i]) begin
      look(VEC[i].addr);
      expect_res("R4/R5/R6/R7", VEC[i].hit, VEC[i].win, VEC[i].pe, VEC[i].addr);
    end

    // R2: no strobe without a request, and the fields hold
    @(negedge clk);
    check("R2", {63'd0, res_valid}, 64'd0);
    check("R2", {56'd0, res_pe}, {56'd0, 8'h21});

    // R11: enabling w0 makes it claim the address ahead of w1
    wr(0, 3, 50'h1);
    look(50'h0000_1000_0010);
    expect_res("R11", 1'b1, 4'd0, 8'h05, 50'h0000_1000_0010);

    // R4 clamp: size 3 acts as 256 bytes, segment = addr[7:0]
    wr(2, 0, 50'h4000_0000); wr(2, 1, 50'd3); wr(2, 3, 50'h3);
    look(50'h0000_4000_00C5);
    expect_res("R4", 1'b1, 4'd2, 8'hC5, 50'h0000_4000_00C5);
    look(50'h0000_4000_0100);
    expect_res("R4", 1'b1, 4'd15, 8'h77, 50'h0000_4000_0100);

    // R8: with the backing window off, an uncovered address misses
    wr(15, 3, 50'h0);
    look(50'h0000_1100_0000);
    expect_res("R8", 1'b0, 4'd0, 8'h00, 50'h0000_1100_0000);

    // R10: re-enable and look up on the same edge -> still old config
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 4'd15; cfg_field = 2'd3; cfg_data = 50'h1;
    lk_valid = 1'b1; lk_addr = 50'h0000_1100_0000;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    expect_res("R10", 1'b0, 4'd0, 8'h00, 50'h0000_1100_0000);
    look(50'h0000_1100_0000);
    expect_res("R10", 1'b1, 4'd15, 8'h77, 50'h0000_1100_0000);

    // R1: reset clears the configuration
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", {63'd0, res_valid}, 64'd0);
    look(50'h0000_1000_0010);
    expect_res("R1", 1'b0, 4'd0, 8'h00, 50'h0000_1000_0010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule